// File: doc/BRIEF.md
# Register Scoreboard with Bypass Control

This block is the hazard unit of a single-issue core. The core has three pipes that are not locked to one another: an ALU pipe, a load/store pipe and a multiply-accumulate pipe. Each architectural register has a pending flag and a producer tag. The tag records whether an in-flight load or an in-flight multiply will write the register. Every cycle the block looks at the instruction that is trying to issue. For each source operand it decides whether to read the register file, to take a bypassed result, or to hold issue until the value exists.

Loads that miss the cache may stay outstanding, up to a fixed limit. Later instructions that do not touch their destinations keep issuing and completing. Multiply results may come back from any of several multiply stages. The pending flag clears on whichever stage reports completion.

The block receives decoded register indices and completion events from the pipes. It drives only the stall line and two forwarding-select codes. The datapath multiplexers use those codes to pick each operand.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset, or in the cycle after a one-cycle `flush`, no register is pending and the outstanding-load count is zero. Every read then selects the register file, and a load can issue.
- R2: `issueKind` encodes 0 = ALU, 1 = load, 2 = multiply. An accepted load or multiply marks its destination pending. An instruction that reads a pending register whose result does not arrive this cycle raises `stall`. `stall` is never high while `issueValid` is low.
- R3: Instructions whose sources and destination are not pending issue without stall while loads are outstanding.
- R4: The forwarding-select encoding is 0 = register file, 1 = ALU result, 2 = load return, 3 = multiply result. A source whose pending load returns on `ldRetValid`/`ldRetIdx` in the same cycle selects 2 without stalling. The return clears the pending flag.
- R5: Multiply write-back may arrive on any stage. Bit k of `mulWbValid` is stage k+2, and its register index is `mulWbIdx[4k+3:4k]`. A matching stage clears the pending multiply destination, and a source reading it in that cycle selects 3.
- R6: A source that is not pending but equals `aluFwdIdx` while `aluFwdValid` is high selects 1. If the register is also pending from a younger load or multiply, the pending producer wins: the block stalls, or selects that producer's code.
- R7: A completion event clears a pending register only when it comes from the pipe recorded as that register's producer.
- R8: If a register is set pending and completes in the same cycle, it stays pending for the new producer.
- R9: At most 4 loads are outstanding. A load issuing with 4 outstanding stalls, unless a load return arrives in the same cycle.
- R10: A multiply stalls while `mulBusy` is high. ALU and load instructions are not held by `mulBusy`.
- R11: An instruction whose destination is pending and not completing this cycle stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all pending state and the load count |
| issueValid | input | 1 | An instruction is trying to issue |
| issueKind | input | 2 | 0 ALU, 1 load, 2 multiply |
| destIdx | input | 4 | Destination register |
| srcAUsed | input | 1 | Operand A reads a register |
| srcAIdx | input | 4 | Operand A register |
| srcBUsed | input | 1 | Operand B reads a register |
| srcBIdx | input | 4 | Operand B register |
| aluFwdValid | input | 1 | ALU result available for bypass |
| aluFwdIdx | input | 4 | Destination of that ALU result |
| ldRetValid | input | 1 | Load data returning this cycle |
| ldRetIdx | input | 4 | Destination of the returning load |
| mulWbValid | input | 4 | Multiply completion per stage (bit k = stage k+2) |
| mulWbIdx | input | 16 | Destination index per completing stage, 4 bits each |
| mulBusy | input | 1 | Multiply unit cannot accept a new operation |
| stall | output | 1 | Hold issue this cycle |
| fwdSelA | output | 2 | Source select for operand A |
| fwdSelB | output | 2 | Source select for operand B |

## Verification
A pending flag stuck high appears at the ports as a stall that never releases on a later read of that register. A flag dropped too early shows up as a register-file select where a stall was due. Both are visible in the first cycle an instruction names the register. A wrong producer tag shows up as the wrong forwarding code, or as a clear from the wrong pipe. A miscounted load total shows up on the first load issued near the limit. The stimulus therefore reads each affected register, or issues a load, directly after the event that changed the state.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    KIND_ALU  = 2'd0,
    KIND_LOAD = 2'd1,
    KIND_MUL  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_ALU  = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_MUL  = 2'd3
  } fwd_e;

  // Strobes from issue control to the tracking state
  typedef struct packed {
    logic setEn;     // mark destination pending
    logic setLoad;   // producer is the load pipe (else multiply)
    logic cntInc;    // one more outstanding load
    logic clearAll;  // flush
  } sb_strobe_t;

endpackage

// File: rtl/sb_track_state.sv
module sb_track_state
  import sb_pkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter int MUL_WB_STAGES = 4,
  parameter int MAX_LOADS     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sb_strobe_t                    strb,
  input  logic [$clog2(NUM_REGS)-1:0]   destIdx,
  input  logic                          ldRetValid,
  input  logic [$clog2(NUM_REGS)-1:0]   ldRetIdx,
  input  logic [MUL_WB_STAGES-1:0]      mulWbValid,
  input  logic [MUL_WB_STAGES*$clog2(NUM_REGS)-1:0] mulWbIdx,
  output logic [NUM_REGS-1:0]           pendVec,
  output logic [NUM_REGS-1:0]           loadVec,
  output logic [NUM_REGS-1:0]           doneVec,
  output logic                          loadsFull
);

  localparam int IW = $clog2(NUM_REGS);
  localparam int CW = $clog2(MAX_LOADS + 1);

  logic [NUM_REGS-1:0] pendQ, pendD;
  logic [NUM_REGS-1:0] loadQ, loadD;
  logic [CW-1:0]       cntQ;
  logic                cntDec;

  function automatic logic mulMatch(input logic [IW-1:0] reg_i);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < MUL_WB_STAGES; k++)
      if (mulWbValid[k] && mulWbIdx[k*IW +: IW] == reg_i) hit = 1'b1;
    return hit;
  endfunction

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    logic ldHit, mulHit, setHit;
    assign ldHit   = ldRetValid && (ldRetIdx == IW'(r));
    assign mulHit  = mulMatch(IW'(r));
    assign setHit  = strb.setEn && (destIdx == IW'(r));
    assign doneVec[r] = pendQ[r] && (loadQ[r] ? ldHit : mulHit);
    // set wins over a clear in the same cycle
    assign pendD[r] = strb.clearAll ? 1'b0 :
                      setHit        ? 1'b1 :
                      doneVec[r]    ? 1'b0 : pendQ[r];
    assign loadD[r] = setHit ? strb.setLoad : loadQ[r];

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      (setHit && !strb.clearAll) |=> pendQ[r]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      loadQ <= '0;
    end else begin
      pendQ <= pendD;
      loadQ <= loadD;
    end
  end

  assign cntDec = ldRetValid && (cntQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strb.clearAll) cntQ <= '0;
    else begin
      case ({strb.cntInc, cntDec})
        2'b10:   cntQ <= cntQ + 1'b1;
        2'b01:   cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
    end
  end

  assign pendVec   = pendQ;
  assign loadVec   = loadQ;
  assign loadsFull = (cntQ == CW'(MAX_LOADS));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CW'(MAX_LOADS));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntInc && loadsFull && !cntDec));
  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (pendQ == '0 && cntQ == '0));

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter int MUL_WB_STAGES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        issueValid,
  input  logic [1:0]                  issueKind,
  input  logic [$clog2(NUM_REGS)-1:0] destIdx,
  input  logic                        srcAUsed,
  input  logic [$clog2(NUM_REGS)-1:0] srcAIdx,
  input  logic                        srcBUsed,
  input  logic [$clog2(NUM_REGS)-1:0] srcBIdx,
  input  logic                        aluFwdValid,
  input  logic [$clog2(NUM_REGS)-1:0] aluFwdIdx,
  input  logic                        ldRetValid,
  input  logic [MUL_WB_STAGES-1:0]    mulWbValid,
  input  logic                        mulBusy,
  input  logic [NUM_REGS-1:0]         pendVec,
  input  logic [NUM_REGS-1:0]         loadVec,
  input  logic [NUM_REGS-1:0]         doneVec,
  input  logic                        loadsFull,
  output logic                        stall,
  output logic [1:0]                  fwdSelA,
  output logic [1:0]                  fwdSelB,
  output sb_strobe_t                  strb
);

  localparam int IW   = $clog2(NUM_REGS);
  localparam int NSRC = 2;

  logic [IW-1:0] srcIdx  [NSRC];
  logic          srcUsed [NSRC];
  logic          srcHaz  [NSRC];
  fwd_e          fwdSel  [NSRC];

  assign srcIdx[0]  = srcAIdx;
  assign srcIdx[1]  = srcBIdx;
  assign srcUsed[0] = srcAUsed;
  assign srcUsed[1] = srcBUsed;

  for (genvar i = 0; i < NSRC; i++) begin : gSrc
    always_comb begin
      srcHaz[i] = 1'b0;
      fwdSel[i] = SEL_RF;
      if (srcUsed[i]) begin
        if (pendVec[srcIdx[i]]) begin
          // tracked producer is younger than anything in the ALU pipe
          if (doneVec[srcIdx[i]])
            fwdSel[i] = loadVec[srcIdx[i]] ? SEL_LOAD : SEL_MUL;
          else
            srcHaz[i] = 1'b1;
        end else if (aluFwdValid && aluFwdIdx == srcIdx[i]) begin
          fwdSel[i] = SEL_ALU;
        end
      end
    end
  end

  logic isLoad, isMul, destHaz, structHaz, accept;

  always_comb begin
    isLoad    = (issueKind == KIND_LOAD);
    isMul     = (issueKind == KIND_MUL);
    destHaz   = pendVec[destIdx] && !doneVec[destIdx];
    structHaz = (isLoad && loadsFull && !ldRetValid) || (isMul && mulBusy);
    stall     = issueValid && (srcHaz[0] || srcHaz[1] || destHaz || structHaz);
    accept    = issueValid && !stall && !flush;
    strb.setEn    = accept && (isLoad || isMul);
    strb.setLoad  = isLoad;
    strb.cntInc   = accept && isLoad;
    strb.clearAll = flush;
  end

  assign fwdSelA = fwdSel[0];
  assign fwdSelB = fwdSel[1];

  assert_stall_needs_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> issueValid);
  assert_load_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA == SEL_LOAD || fwdSelB == SEL_LOAD) |-> ldRetValid);
  assert_mul_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA == SEL_MUL || fwdSelB == SEL_MUL) |-> (mulWbValid != '0));
  assert_busy_holds_mul_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueKind == KIND_MUL && mulBusy) |-> stall);

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter int MUL_WB_STAGES = 4,
  parameter int MAX_LOADS     = 4
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     flush,
  input  logic                                     issueValid,
  input  logic [1:0]                               issueKind,
  input  logic [$clog2(NUM_REGS)-1:0]              destIdx,
  input  logic                                     srcAUsed,
  input  logic [$clog2(NUM_REGS)-1:0]              srcAIdx,
  input  logic                                     srcBUsed,
  input  logic [$clog2(NUM_REGS)-1:0]              srcBIdx,
  input  logic                                     aluFwdValid,
  input  logic [$clog2(NUM_REGS)-1:0]              aluFwdIdx,
  input  logic                                     ldRetValid,
  input  logic [$clog2(NUM_REGS)-1:0]              ldRetIdx,
  input  logic [MUL_WB_STAGES-1:0]                 mulWbValid,
  input  logic [MUL_WB_STAGES*$clog2(NUM_REGS)-1:0] mulWbIdx,
  input  logic                                     mulBusy,
  output logic                                     stall,
  output logic [1:0]                               fwdSelA,
  output logic [1:0]                               fwdSelB
);

  sb_strobe_t          strb;
  logic [NUM_REGS-1:0] pendVec, loadVec, doneVec;
  logic                loadsFull;

  sb_issue_ctrl #(.NUM_REGS(NUM_REGS), .MUL_WB_STAGES(MUL_WB_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .issueValid(issueValid), .issueKind(issueKind), .destIdx(destIdx),
    .srcAUsed(srcAUsed), .srcAIdx(srcAIdx), .srcBUsed(srcBUsed), .srcBIdx(srcBIdx),
    .aluFwdValid(aluFwdValid), .aluFwdIdx(aluFwdIdx),
    .ldRetValid(ldRetValid), .mulWbValid(mulWbValid), .mulBusy(mulBusy),
    .pendVec(pendVec), .loadVec(loadVec), .doneVec(doneVec), .loadsFull(loadsFull),
    .stall(stall), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .strb(strb)
  );

  sb_track_state #(.NUM_REGS(NUM_REGS), .MUL_WB_STAGES(MUL_WB_STAGES),
                   .MAX_LOADS(MAX_LOADS)) uState (
    .clk(clk), .rstN(rstN), .strb(strb), .destIdx(destIdx),
    .ldRetValid(ldRetValid), .ldRetIdx(ldRetIdx),
    .mulWbValid(mulWbValid), .mulWbIdx(mulWbIdx),
    .pendVec(pendVec), .loadVec(loadVec), .doneVec(doneVec), .loadsFull(loadsFull)
  );

endmodule

// File: tb/reg_scoreboard_test.sv
module reg_scoreboard_test;

  localparam int PERIOD = 10;
  localparam int NV     = 28;

  logic        clk = 1'b0;
  logic        rstN, flush, issueValid, srcAUsed, srcBUsed;
  logic [1:0]  issueKind;
  logic [3:0]  destIdx, srcAIdx, srcBIdx, aluFwdIdx, ldRetIdx;
  logic        aluFwdValid, ldRetValid, mulBusy;
  logic [3:0]  mulWbValid;
  logic [15:0] mulWbIdx;
  logic        stall;
  logic [1:0]  fwdSelA, fwdSelB;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  reg_scoreboard uut (
    .clk(clk), .rstN(rstN), .flush(flush), .issueValid(issueValid),
    .issueKind(issueKind), .destIdx(destIdx), .srcAUsed(srcAUsed), .srcAIdx(srcAIdx),
    .srcBUsed(srcBUsed), .srcBIdx(srcBIdx), .aluFwdValid(aluFwdValid),
    .aluFwdIdx(aluFwdIdx), .ldRetValid(ldRetValid), .ldRetIdx(ldRetIdx),
    .mulWbValid(mulWbValid), .mulWbIdx(mulWbIdx), .mulBusy(mulBusy),
    .stall(stall), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  typedef struct packed {
    logic       iv;  logic [1:0] kind; logic [3:0] dst;
    logic       au;  logic [3:0] sa;
    logic       bu;  logic [3:0] sb;
    logic       lv;  logic [3:0] li;
    logic       mv;  logic [1:0] ms;   logic [3:0] mi;
    logic       fv;  logic [3:0] fi;
    logic       busy;
    logic       xs;  logic [1:0] xa;   logic [1:0] xb;
    logic [3:0] req;
  } vec_t;

  // iv kind dst | au sa | bu sb | lv li | mv ms mi | fv fi | busy | xs xa xb | req
  localparam vec_t VECS [NV] = '{
    '{1,0,1,  1,2,  1,3,  0,0,  0,0,0,  0,0, 0, 0,0,0, 3},  // R3 idle ALU
    '{1,1,5,  1,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 2},  // R2 load r5
    '{1,0,6,  1,5,  0,0,  0,0,  0,0,0,  0,0, 0, 1,0,0, 2},  // R2 read pending r5
    '{0,0,6,  1,5,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 2},  // R2 no issue, no stall
    '{1,0,7,  1,2,  1,3,  0,0,  0,0,0,  0,0, 0, 0,0,0, 3},  // R3 hit-under-miss
    '{1,2,8,  1,1,  1,2,  0,0,  0,0,0,  0,0, 0, 0,0,0, 3},  // R3 mul r8
    '{1,0,6,  1,5,  1,8,  1,5,  0,0,0,  0,0, 0, 1,2,0, 4},  // R4 load returns, B waits
    '{1,0,6,  1,5,  1,8,  0,0,  1,2,8,  0,0, 0, 0,0,3, 5},  // R5 mul stage 4
    '{1,2,9,  0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 5},  // R5 mul r9
    '{1,0,10, 1,9,  1,4,  0,0,  1,3,9,  1,4, 0, 0,3,1, 5},  // R5 stage 5, R6 ALU bypass
    '{1,1,4,  0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 6},  // R6 load r4
    '{1,0,10, 1,4,  0,0,  0,0,  0,0,0,  1,4, 0, 1,0,0, 6},  // R6 pending beats ALU
    '{1,0,10, 1,4,  0,0,  1,4,  0,0,0,  1,4, 0, 0,2,0, 6},  // R6 load return wins
    '{1,1,11, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 8},  // R8 load r11
    '{1,1,11, 0,0,  0,0,  1,11, 0,0,0,  0,0, 0, 0,0,0, 8},  // R8 set with clear
    '{1,0,10, 1,11, 0,0,  0,0,  0,0,0,  0,0, 0, 1,0,0, 8},  // R8 still pending
    '{1,0,10, 1,11, 0,0,  0,0,  1,0,11, 0,0, 0, 1,0,0, 7},  // R7 mul event, load producer
    '{1,1,12, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 9},  // R9 count 2
    '{1,1,13, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 9},  // R9 count 3
    '{1,1,14, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 0,0,0, 9},  // R9 count 4
    '{1,1,15, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 1,0,0, 9},  // R9 fifth stalls
    '{1,1,15, 0,0,  0,0,  1,12, 0,0,0,  0,0, 0, 0,0,0, 9},  // R9 return frees slot
    '{1,1,0,  0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 1,0,0, 9},  // R9 full again
    '{1,2,1,  0,0,  0,0,  0,0,  0,0,0,  0,0, 1, 1,0,0, 10}, // R10 mul busy
    '{1,0,3,  0,0,  0,0,  0,0,  0,0,0,  0,0, 1, 0,0,0, 10}, // R10 ALU ignores busy
    '{1,0,13, 0,0,  0,0,  0,0,  0,0,0,  0,0, 0, 1,0,0, 11}, // R11 dest pending
    '{1,2,13, 0,0,  0,0,  1,13, 0,0,0,  0,0, 0, 0,0,0, 11}, // R11 dest completing
    '{1,0,3,  1,13, 0,0,  1,13, 0,0,0,  0,0, 0, 1,0,0, 7}   // R7 load event, mul producer
  };

  task automatic idle();
    flush = 0; issueValid = 0; issueKind = 0; destIdx = 0;
    srcAUsed = 0; srcAIdx = 0; srcBUsed = 0; srcBIdx = 0;
    aluFwdValid = 0; aluFwdIdx = 0; ldRetValid = 0; ldRetIdx = 0;
    mulWbValid = 0; mulWbIdx = 0; mulBusy = 0;
  endtask

  task automatic drive(input vec_t v);
    idle();
    issueValid = v.iv; issueKind = v.kind; destIdx = v.dst;
    srcAUsed = v.au; srcAIdx = v.sa; srcBUsed = v.bu; srcBIdx = v.sb;
    ldRetValid = v.lv; ldRetIdx = v.li;
    if (v.mv) begin
      mulWbValid = 4'b0001 << v.ms;
      mulWbIdx[v.ms*4 +: 4] = v.mi;
    end
    aluFwdValid = v.fv; aluFwdIdx = v.fi; mulBusy = v.busy;
  endtask

  task automatic check(input int req, input logic [4:0] exp);
    nChecks++;
    if ({stall, fwdSelA, fwdSelB} !== exp) begin
      nFails++;
      $display("FAIL R%0d stall/selA/selB actual %b/%0d/%0d expected %b/%0d/%0d",
               req, stall, fwdSelA, fwdSelB, exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  task automatic issueLoad(input logic [3:0] dst);
    idle(); issueValid = 1; issueKind = 1; destIdx = dst;
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #(PERIOD/4) check(1, 5'b0);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #(PERIOD/4) check(int'(VECS[i].req), {VECS[i].xs, VECS[i].xa, VECS[i].xb});
    end

    // R1 flush clears pending flags and load count
    @(negedge clk); idle(); flush = 1;
    @(negedge clk);
    issueLoad(2); srcAUsed = 1; srcAIdx = 11; srcBUsed = 1; srcBIdx = 15;
    #(PERIOD/4) check(1, 5'b0);
    for (int d = 3; d <= 5; d++) begin
      @(negedge clk); issueLoad(4'(d));
      #(PERIOD/4) check(1, 5'b0);   // R1 count restarted at zero
    end
    @(negedge clk); issueLoad(6);
    #(PERIOD/4) check(9, 5'b10000); // R9 limit after flush

    // R1 reset mid-run
    @(negedge clk); idle(); rstN = 0;
    @(negedge clk); rstN = 1;
    @(negedge clk);
    idle(); issueValid = 1; destIdx = 7; srcAUsed = 1; srcAIdx = 2;
    srcBUsed = 1; srcBIdx = 3;
    #(PERIOD/4) check(1, 5'b0);

    @(negedge clk); idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule